// File: doc/BRIEF.md
# Multiplexed-Address Byte Bus Master

This block carries out one single-byte read or write at a time on an 8-bit bus whose data lines also carry the address. A host offers a request through a valid/ready handshake. The request holds a direction flag, a 16-bit address, a byte to write and a chip index. The block then runs a fixed sequence on the bus pins.

The sequence starts with the two address bytes. Each byte is presented on the shared data lines under its own latch strobe, the low byte first and the high byte second. The block then either drives the write byte or releases the data lines so the peripheral can drive them. It pulls down the select line of the chosen chip, and after that the read or write strobe. It then waits for the peripheral's active-low acknowledge. When the acknowledge comes, it samples the data lines and returns every control line to its idle level. If no acknowledge arrives within a programmable number of cycles, it gives up. It reports the end of every transaction with a one-cycle done pulse, and reports a timeout with a flag beside that pulse and a sticky error bit.

Each setup or hold step lasts `PHASE_CYC` clocks (default 2). The wait limit is `TIMEOUT_CYC` clocks (default 50000, which is 1 ms at 50 MHz).

Top module: `mxbus_master`

## Requirements
- R1: After reset, both chip selects, the read strobe and the write strobe are high. Both address strobes are low. The data lines are driven (`bus_oe`=1). `req_ready`=1, and `rsp_done`, `rsp_timeout` and `err_flag` are 0.
- R2: In the first PHASE_CYC cycles after a request is accepted, `bus_alo`=1, `bus_oe`=1 and `bus_dout` carries address bits 7:0. In the next PHASE_CYC cycles, `bus_alo`=0 and the low byte stays on the bus. In both steps all selects and strobes are inactive.
- R3: The next PHASE_CYC cycles have `bus_ahi`=1 with address bits 15:8 on `bus_dout`. PHASE_CYC more cycles follow with `bus_ahi`=0 and the high byte still driven. Selects and strobes stay inactive throughout.
- R4: From the data step until the end of the transaction, a write drives the write byte with `bus_oe`=1, and a read holds `bus_oe`=0. The data step lasts PHASE_CYC cycles, with selects and strobes inactive.
- R5: After the data step, exactly one select goes low: bit 0 of `bus_cs_n` for chip index 0, bit 1 for chip index 1. It stays low for the rest of the transaction. PHASE_CYC cycles later, `bus_rd_n` goes low for a read or `bus_wr_n` goes low for a write, and the other strobe stays high.
- R6: If `bus_ack_n` is sampled low at a clock edge while a strobe is low, then in the following cycle `rsp_done`=1, `rsp_rdata` holds the `bus_din` value seen at that edge, and all selects and strobes are high.
- R7: If the strobe has been low for TIMEOUT_CYC cycles without an acknowledge, the transaction ends the same way, but with `rsp_timeout`=1. `err_flag` then goes to 1 and stays 1 until reset.
- R8: `req_ready` is 1 only while the bus is idle. A request offered while a transaction is running changes nothing on the bus. After completion the bus stays idle unless a new request is offered.
- R9: `rsp_done` lasts exactly one cycle, and `rsp_timeout` is 0 for a transaction that ends by acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transaction address |
| req_wdata | input | 8 | Byte to write |
| req_chip | input | 1 | Target chip index |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte sampled on acknowledge |
| rsp_timeout | output | 1 | Marks a completion by timeout |
| err_flag | output | 1 | Sticky timeout indicator |
| bus_dout | output | 8 | Data/address lines, outgoing value |
| bus_oe | output | 1 | Output enable of the data lines |
| bus_din | input | 8 | Data lines, incoming value |
| bus_alo | output | 1 | Low address byte latch strobe |
| bus_ahi | output | 1 | High address byte latch strobe |
| bus_cs_n | output | 2 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ack_n | input | 1 | Active-low acknowledge from the peripheral |

## Verification
The bench counts cycle k from the first falling edge after the accepting clock edge:
- The bus pins are due in step k/PHASE_CYC. Step 0 is the low address latch, step 1 the low address hold, step 2 the high address latch, step 3 the high address hold, step 4 data, step 5 select, and step 6 onward the strobe.
- A bench that raises the acknowledge at cycle 6·PHASE_CYC+D expects `rsp_done` and idle pins at cycle 6·PHASE_CYC+D+1. With no acknowledge, it expects them at 6·PHASE_CYC+TIMEOUT_CYC.

Every pin is compared at each falling edge of that walk against the step it is due in. The done cycle is found by the count, not by waiting for the pulse. The cycle after it is checked for a dropped pulse and an idle bus.

// File: rtl/mxb_pkg.sv
// Package: shared sizes, sequencer state encoding and the request record
// of the multiplexed-address byte bus master.
// Assumes: a two-byte address carried over a byte-wide data bus.
package mxb_pkg;

    localparam int unsigned MXB_DW     = 8;
    localparam int unsigned MXB_AW     = 2 * MXB_DW;
    localparam int unsigned MXB_NCHIP  = 2;
    localparam int unsigned MXB_CHIP_W = (MXB_NCHIP > 1) ? $clog2(MXB_NCHIP) : 1;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ALO_SET  = 3'd1,
        ST_ALO_HOLD = 3'd2,
        ST_AHI_SET  = 3'd3,
        ST_AHI_HOLD = 3'd4,
        ST_DATA     = 3'd5,
        ST_SEL      = 3'd6,
        ST_STRB     = 3'd7
    } mxb_state_e;

    typedef struct packed {
        logic                  wr;
        logic [MXB_AW-1:0]     addr;
        logic [MXB_DW-1:0]     wdata;
        logic [MXB_CHIP_W-1:0] chip;
    } mxb_req_t;

endpackage

// File: rtl/mxb_cycle_timer.sv
// Module: mxb_cycle_timer
// Counts clocks spent in the current sequencer step. It flags the end of a
// setup/hold step and the expiry of the acknowledge wait.
// Assumes: restart is pulsed in the cycle the step changes, and both limits are >= 1.
module mxb_cycle_timer #(
    parameter int unsigned PHASE_CYC   = 2,
    parameter int unsigned TIMEOUT_CYC = 50000,
    localparam int unsigned LIMIT      = (PHASE_CYC > TIMEOUT_CYC) ? PHASE_CYC : TIMEOUT_CYC,
    localparam int unsigned CNT_W      = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic phase_end,
    output logic wait_expired
);

    logic [CNT_W-1:0] cnt;

    // Count cycles in the step; saturate so a stuck step cannot wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Decode the two limits from the running count.
    always_comb begin
        phase_end    = (cnt == CNT_W'(PHASE_CYC - 1));
        wait_expired = (cnt == CNT_W'(TIMEOUT_CYC - 1));
    end

endmodule

// File: rtl/mxb_sequencer.sv
// Module: mxb_sequencer
// Walks one transaction through the address, data, select and strobe
// steps. It holds the accepted request and produces the completion response.
// Assumes: the bus acknowledge is already synchronous to clk.
module mxb_sequencer
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  mxb_req_t          req_in,
    input  logic              ack_n,
    input  logic [MXB_DW-1:0] din,
    input  logic              phase_end,
    input  logic              wait_expired,
    output logic              req_ready,
    output mxb_state_e        state,
    output mxb_req_t          req_q,
    output logic              restart,
    output logic              done,
    output logic              timed_out,
    output logic [MXB_DW-1:0] rdata,
    output logic              err
);

    mxb_state_e state_nxt;
    logic       finish_ack;
    logic       finish_tmo;

    // Choose the next step from the current one and the timer.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_nxt = ST_ALO_SET;
            ST_ALO_SET:  if (phase_end) state_nxt = ST_ALO_HOLD;
            ST_ALO_HOLD: if (phase_end) state_nxt = ST_AHI_SET;
            ST_AHI_SET:  if (phase_end) state_nxt = ST_AHI_HOLD;
            ST_AHI_HOLD: if (phase_end) state_nxt = ST_DATA;
            ST_DATA:     if (phase_end) state_nxt = ST_SEL;
            ST_SEL:      if (phase_end) state_nxt = ST_STRB;
            ST_STRB:     if (finish_ack || finish_tmo) state_nxt = ST_IDLE;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    // Completion conditions and the handshake/timer side signals.
    always_comb begin
        finish_ack = (state == ST_STRB) && !ack_n;
        finish_tmo = (state == ST_STRB) && ack_n && wait_expired;
        restart    = (state_nxt != state);
        req_ready  = (state == ST_IDLE);
    end

    // Register the step and capture the request at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            req_q <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && req_valid) begin
                req_q <= req_in;
            end
        end
    end

    // Produce the done pulse, the read byte, the timeout mark and the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            timed_out <= 1'b0;
            rdata     <= '0;
            err       <= 1'b0;
        end else begin
            done      <= finish_ack || finish_tmo;
            timed_out <= finish_tmo;
            if (finish_ack) begin
                rdata <= din;
            end
            if (finish_tmo) begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mxb_pin_driver.sv
// Module: mxb_pin_driver
// Decodes the registered step and the held request into the bus pin levels.
// Assumes: the inputs come straight from flops, so every pin follows one
// decode of stable registered values.
module mxb_pin_driver
    import mxb_pkg::*;
(
    input  mxb_state_e           state,
    input  mxb_req_t             req_q,
    output logic [MXB_DW-1:0]    dout,
    output logic                 oe,
    output logic                 alo,
    output logic                 ahi,
    output logic [MXB_NCHIP-1:0] cs_n,
    output logic                 rd_n,
    output logic                 wr_n
);

    logic sel_on;
    logic strb_on;

    // Data lines and the two address latch strobes.
    always_comb begin
        dout    = '0;
        oe      = 1'b1;
        alo     = 1'b0;
        ahi     = 1'b0;
        sel_on  = 1'b0;
        strb_on = 1'b0;
        unique case (state)
            ST_ALO_SET: begin
                dout = req_q.addr[MXB_DW-1:0];
                alo  = 1'b1;
            end
            ST_ALO_HOLD: dout = req_q.addr[MXB_DW-1:0];
            ST_AHI_SET: begin
                dout = req_q.addr[MXB_AW-1:MXB_DW];
                ahi  = 1'b1;
            end
            ST_AHI_HOLD: dout = req_q.addr[MXB_AW-1:MXB_DW];
            ST_DATA, ST_SEL, ST_STRB: begin
                dout    = req_q.wr ? req_q.wdata : '0;
                oe      = req_q.wr;
                sel_on  = (state != ST_DATA);
                strb_on = (state == ST_STRB);
            end
            default: ;
        endcase
    end

    // One active-low select per chip, only for the held index.
    for (genvar g = 0; g < MXB_NCHIP; g++) begin : g_cs
        always_comb cs_n[g] = !(sel_on && (req_q.chip == MXB_CHIP_W'(g)));
    end

    // Direction strobes during the wait step.
    always_comb begin
        rd_n = !(strb_on && !req_q.wr);
        wr_n = !(strb_on &&  req_q.wr);
    end

endmodule

// File: rtl/mxbus_master.sv
// Module: mxbus_master
// Single-byte master for a byte-wide bus with a multiplexed two-byte address.
// It runs low address, high address, data, select, strobe and then waits for
// an acknowledge or a timeout.
// Assumes: bus_ack_n and bus_din are synchronous to clk.
module mxbus_master
    import mxb_pkg::*;
#(
    parameter int unsigned PHASE_CYC   = 2,
    parameter int unsigned TIMEOUT_CYC = 50000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [MXB_AW-1:0]     req_addr,
    input  logic [MXB_DW-1:0]     req_wdata,
    input  logic [MXB_CHIP_W-1:0] req_chip,
    output logic                  rsp_done,
    output logic [MXB_DW-1:0]     rsp_rdata,
    output logic                  rsp_timeout,
    output logic                  err_flag,
    output logic [MXB_DW-1:0]     bus_dout,
    output logic                  bus_oe,
    input  logic [MXB_DW-1:0]     bus_din,
    output logic                  bus_alo,
    output logic                  bus_ahi,
    output logic [MXB_NCHIP-1:0]  bus_cs_n,
    output logic                  bus_rd_n,
    output logic                  bus_wr_n,
    input  logic                  bus_ack_n
);

    mxb_req_t   req_in;
    mxb_req_t   req_q;
    mxb_state_e state;
    logic       restart;
    logic       phase_end;
    logic       wait_expired;

    // Pack the host request fields.
    always_comb req_in = '{wr: req_write, addr: req_addr, wdata: req_wdata, chip: req_chip};

    mxb_cycle_timer #(
        .PHASE_CYC  (PHASE_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .phase_end   (phase_end),
        .wait_expired(wait_expired)
    );

    mxb_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_in      (req_in),
        .ack_n       (bus_ack_n),
        .din         (bus_din),
        .phase_end   (phase_end),
        .wait_expired(wait_expired),
        .req_ready   (req_ready),
        .state       (state),
        .req_q       (req_q),
        .restart     (restart),
        .done        (rsp_done),
        .timed_out   (rsp_timeout),
        .rdata       (rsp_rdata),
        .err         (err_flag)
    );

    mxb_pin_driver u_pins (
        .state(state),
        .req_q(req_q),
        .dout (bus_dout),
        .oe   (bus_oe),
        .alo  (bus_alo),
        .ahi  (bus_ahi),
        .cs_n (bus_cs_n),
        .rd_n (bus_rd_n),
        .wr_n (bus_wr_n)
    );

endmodule

// File: rtl/mxbus_master_chk.sv
// Module: mxbus_master_chk
// Protocol checks on the ports of mxbus_master. It is attached with bind.
module mxbus_master_chk
    import mxb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic                 rsp_done,
    input logic                 rsp_timeout,
    input logic                 err_flag,
    input logic                 bus_oe,
    input logic                 bus_alo,
    input logic                 bus_ahi,
    input logic [MXB_NCHIP-1:0] bus_cs_n,
    input logic                 bus_rd_n,
    input logic                 bus_wr_n,
    input logic                 bus_ack_n
);

    // R5
    single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bus_cs_n) <= 1);

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R5
    strobe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> (bus_cs_n != {MXB_NCHIP{1'b1}}));

    // R2
    latch_strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_alo || bus_ahi) |-> (!(bus_alo && bus_ahi) && bus_oe && bus_rd_n && bus_wr_n
                                   && bus_cs_n == {MXB_NCHIP{1'b1}}));

    // R4
    released_only_for_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_wr_n);

    // R6
    ack_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!bus_rd_n || !bus_wr_n) && !bus_ack_n) |=> (rsp_done && !rsp_timeout));

    // R6
    done_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (bus_rd_n && bus_wr_n && bus_cs_n == {MXB_NCHIP{1'b1}}));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R7
    timeout_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> (rsp_done && err_flag));

    // R8
    ready_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_rd_n && bus_wr_n && !bus_alo && !bus_ahi
                       && bus_cs_n == {MXB_NCHIP{1'b1}}));

endmodule

bind mxbus_master mxbus_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .rsp_timeout(rsp_timeout),
    .err_flag   (err_flag),
    .bus_oe     (bus_oe),
    .bus_alo    (bus_alo),
    .bus_ahi    (bus_ahi),
    .bus_cs_n   (bus_cs_n),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_ack_n  (bus_ack_n)
);

// File: tb/mxbus_master_tb.sv
// Directed bench for mxbus_master: one task per scenario, each checking itself.
module mxbus_master_tb;

    localparam int P = 3;
    localparam int T = 40;
    localparam int WATCHDOG = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [0:0] req_chip = '0;
    logic       rsp_done;
    logic [7:0] rsp_rdata;
    logic       rsp_timeout;
    logic       err_flag;
    logic [7:0] bus_dout;
    logic       bus_oe;
    logic [7:0] bus_din = '0;
    logic       bus_alo;
    logic       bus_ahi;
    logic [1:0] bus_cs_n;
    logic       bus_rd_n;
    logic       bus_wr_n;
    logic       bus_ack_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mxbus_master #(.PHASE_CYC(P), .TIMEOUT_CYC(T)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_chip(req_chip),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
        .err_flag(err_flag),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
        .bus_alo(bus_alo), .bus_ahi(bus_ahi), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ack_n(bus_ack_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Pin vector {alo, ahi, oe, cs_n[1:0], rd_n, wr_n, dout[7:0]}
    function automatic logic [14:0] pins_now();
        return {bus_alo, bus_ahi, bus_oe, bus_cs_n, bus_rd_n, bus_wr_n,
                (bus_oe ? bus_dout : 8'h00)};
    endfunction

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pins_now() == {3'b001, 2'b11, 2'b11, 8'h00}, "R1 pins", pins_now(),
              {3'b001, 2'b11, 2'b11, 8'h00});
        check({req_ready, rsp_done, rsp_timeout, err_flag} == 4'b1000, "R1 status",
              {req_ready, rsp_done, rsp_timeout, err_flag}, 4'b1000);
    endtask

    // One transaction, walked cycle by cycle. ack_dly < 0 means no acknowledge.
    // busy_poke offers a second request while busy (R8).
    task automatic t_txn(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                         input bit chip, input int ack_dly, input logic [7:0] rd_val,
                         input bit busy_poke, input bit err_before);
        int last;
        logic [1:0] sel_exp;
        check(req_ready === 1'b1, "R8 ready before", {31'd0, req_ready}, 32'd1);
        check(err_flag === err_before, "R7 err before", {31'd0, err_flag}, {31'd0, err_before});
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        req_chip  = chip;
        bus_din   = rd_val;
        @(posedge clk);
        @(negedge clk);
        if (busy_poke) begin
            req_write = ~wr;
            req_addr  = ~addr;
            req_wdata = ~wd;
            req_chip  = ~chip;
        end else begin
            req_valid = 1'b0;
        end
        last    = (ack_dly >= 0) ? 6 * P + ack_dly + 1 : 6 * P + T;
        sel_exp = chip ? 2'b01 : 2'b10;
        for (int i = 0; i < last; i++) begin
            int ph;
            logic [14:0] e;
            string tag;
            ph = (i / P > 6) ? 6 : i / P;
            case (ph)
                0: begin e = {3'b101, 2'b11, 2'b11, addr[7:0]};  tag = "R2"; end
                1: begin e = {3'b001, 2'b11, 2'b11, addr[7:0]};  tag = "R2"; end
                2: begin e = {3'b011, 2'b11, 2'b11, addr[15:8]}; tag = "R3"; end
                3: begin e = {3'b001, 2'b11, 2'b11, addr[15:8]}; tag = "R3"; end
                4: begin e = {2'b00, wr, 2'b11, 2'b11, wr ? wd : 8'h00}; tag = "R4"; end
                5: begin e = {2'b00, wr, sel_exp, 2'b11, wr ? wd : 8'h00}; tag = "R5"; end
                default: begin
                    e = {2'b00, wr, sel_exp, wr, ~wr, wr ? wd : 8'h00}; tag = "R5";
                end
            endcase
            check(pins_now() == e, tag, pins_now(), e);
            check(req_ready === 1'b0 && rsp_done === 1'b0, "R8 busy",
                  {req_ready, rsp_done}, 2'b00);
            if (busy_poke && i == 6 * P) req_valid = 1'b0;
            if (ack_dly >= 0 && i == 6 * P + ack_dly) bus_ack_n = 1'b0;
            @(negedge clk);
        end
        bus_ack_n = 1'b1;
        check(rsp_done === 1'b1, "R6 done due", {31'd0, rsp_done}, 32'd1);
        check(pins_now() == {3'b001, 2'b11, 2'b11, 8'h00}, "R6 bus idle at done", pins_now(),
              {3'b001, 2'b11, 2'b11, 8'h00});
        if (ack_dly >= 0) begin
            check(rsp_timeout === 1'b0, "R9 no timeout", {31'd0, rsp_timeout}, 32'd0);
            if (!wr) check(rsp_rdata === rd_val, "R6 read data", {24'd0, rsp_rdata},
                           {24'd0, rd_val});
            check(err_flag === err_before, "R7 err unchanged", {31'd0, err_flag},
                  {31'd0, err_before});
        end else begin
            check(rsp_timeout === 1'b1, "R7 timeout flag", {31'd0, rsp_timeout}, 32'd1);
            check(err_flag === 1'b1, "R7 err set", {31'd0, err_flag}, 32'd1);
        end
        check(req_ready === 1'b1, "R8 ready after", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        check(rsp_done === 1'b0, "R9 pulse width", {31'd0, rsp_done}, 32'd0);
        check(bus_alo === 1'b0 && req_ready === 1'b1, "R8 no stray start",
              {bus_alo, req_ready}, 2'b01);
    endtask

    bit wd_hit = 1'b0;

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        wd_hit = 1'b1;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();                                                  // R1
        t_txn(1'b1, 16'h12A5, 8'h3C, 1'b0, 2,  8'h00, 1'b0, 1'b0);  // R2 R3 R4 R5 R6 R9 write chip 0
        t_txn(1'b0, 16'hF00D, 8'hFF, 1'b1, 0,  8'h96, 1'b0, 1'b0);  // R6 read chip 1, immediate ack
        t_txn(1'b0, 16'h0180, 8'h00, 1'b0, 5,  8'h5A, 1'b0, 1'b0);  // R6 read chip 0
        t_txn(1'b1, 16'hBEEF, 8'hC3, 1'b1, T - 1, 8'h00, 1'b0, 1'b0); // R6 ack on the last wait cycle
        t_txn(1'b1, 16'h7E81, 8'h24, 1'b1, -1, 8'h00, 1'b0, 1'b0);  // R7 timeout
        t_txn(1'b0, 16'h4321, 8'h00, 1'b1, 1,  8'hA7, 1'b0, 1'b1);  // R7 sticky error
        t_txn(1'b1, 16'h55AA, 8'h69, 1'b0, 3,  8'h00, 1'b1, 1'b1);  // R8 request while busy
        if (!wd_hit) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule